// File: doc/BRIEF.md
# Safety Error Status Aggregator

This block gathers hardware safety error events from three places in a network controller: the MAC control path, the queue memories and the DMA memory. Each source reports errors as single-cycle pulses on a bit vector. The block captures every pulse into a sticky status bit. Software reads the bit over a simple register bus and clears it by writing back a one. The block keeps a correctable-interrupt enable bit for each protected memory. From the status and the enables it forms two read-only summary registers and one level interrupt. Correctable and uncorrectable conditions are kept apart in those summaries.

A build-time safety level selects which protection groups exist. Level 0 has no safety logic. Level 1 adds the queue and DMA memory error groups. Level 2 adds the control-path parity and timeout bits. Level 3 also adds the two external-interface parity bits. At any level, status bits that are not implemented read as zero and ignore their pulses.

Top module: `safety_err_agg`

## Requirements
- R1: After reset, every register (offsets 0 to 6) reads zero and `irq_o` is low.
- R2: A pulse on an implemented event bit sets the matching status bit at the next clock edge. The bit then stays set until software clears it.
- R3: A bus write to a status register (offset 0 control, 1 queue memory, 2 DMA memory) clears each bit written as one and leaves each bit written as zero unchanged.
- R4: When an event pulse and a write-one clear hit the same bit in the same cycle, the bit is set after that edge.
- R5: Control status (offset 0) implements bits 1-4, 6-19 and 24 at level 2 and above. It implements bits 0 and 5 (external-interface parity) only at level 3. All other bits read zero.
- R6: Queue-memory status (offset 1) has four 4-bit groups: TX at bits 0-3, RX at 4-7, schedule table at 8-11 and parser at 12-15. Within a group, bit 0 is correctable, bit 1 is address mismatch and bit 2 is uncorrectable. Bit 3 reads zero. DMA-memory status (offset 2) uses bits 0/1/2 with the same meanings. Both registers are implemented from level 1 up.
- R7: At level 0 every register reads zero, pulses and writes have no effect, and `irq_o` stays low.
- R8: Correctable-interrupt enables are read/write. At offset 3, bit 0 is TX, bit 1 RX, bit 2 schedule table and bit 3 parser. At offset 4, bit 0 is the DMA memory. All other bits read zero, and all enable bits read zero at level 0.
- R9: Summary Q (offset 5) is read-only: bit 0 = OR of control status, bit 1 = OR of queue correctable bits whose enable is set, bit 2 = OR of queue mismatch and uncorrectable bits. Summary D (offset 6) is read-only: bit 0 = OR of control status, bit 1 = DMA correctable AND its enable, bit 2 = DMA mismatch OR uncorrectable. Writes to either summary are ignored.
- R10: `irq_o` is the OR of all summary flags, taken from the current register state in the same cycle. Uncorrectable, mismatch and control errors therefore always raise it. A correctable error raises it only when that memory's enable is set.
- R11: Reads of offset 7, or of any offset above 6, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_evt_i | input | 32 | Control-path error pulses |
| qm_evt_i | input | 16 | Queue-memory error pulses |
| dm_evt_i | input | 3 | DMA-memory error pulses |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Safety interrupt |

## Verification
The assertions assume that event pulses and bus writes are stable across the sampling clock edge. They also assume that, at a given edge, a status bit is changed only by its own pulse or its own write-one. The bench drives every input at the falling edge and holds it through the rising edge, so both assumptions hold. Random pulses land on any bit, including reserved and unimplemented ones. Random writes go to every offset, including the summaries and the unmapped offset. Three instances at levels 3, 1 and 0 share the same stimulus, so each level's masking is checked against the same traffic.

// File: rtl/safety_agg_pkg.sv
package safety_agg_pkg;
   localparam int DATA_W     = 32;
   localparam int QM_GROUPS  = 4;
   localparam int GRP_W      = 4;
   localparam int QM_W       = QM_GROUPS * GRP_W;
   localparam int DM_W       = 3;
   localparam int POS_CORR   = 0;
   localparam int POS_AMIS   = 1;
   localparam int POS_UNC    = 2;

   typedef enum logic [2:0] {
      RA_CTL  = 3'd0,
      RA_QMEM = 3'd1,
      RA_DMEM = 3'd2,
      RA_QEN  = 3'd3,
      RA_DEN  = 3'd4,
      RA_SUMQ = 3'd5,
      RA_SUMD = 3'd6
   } reg_addr_e;

   localparam logic [DATA_W-1:0] CTL_CORE_BITS  = 32'h010F_FFDE;
   localparam logic [DATA_W-1:0] CTL_EXTIF_BITS = 32'h0000_0021;

   function automatic logic [DATA_W-1:0] ctl_impl(input int lvl);
      logic [DATA_W-1:0] m;
      m = '0;
      if (lvl >= 2) m = m | CTL_CORE_BITS;
      if (lvl >= 3) m = m | CTL_EXTIF_BITS;
      return m;
   endfunction

   function automatic logic [QM_W-1:0] qm_impl(input int lvl);
      logic [QM_W-1:0] m;
      m = '0;
      if (lvl >= 1)
         for (int g = 0; g < QM_GROUPS; g++) begin
            m[g*GRP_W+POS_CORR] = 1'b1;
            m[g*GRP_W+POS_AMIS] = 1'b1;
            m[g*GRP_W+POS_UNC]  = 1'b1;
         end
      return m;
   endfunction

   function automatic logic [DM_W-1:0] dm_impl(input int lvl);
      return (lvl >= 1) ? {DM_W{1'b1}} : '0;
   endfunction
endpackage

// File: rtl/sticky_w1c_reg.sv
module sticky_w1c_reg #(
   parameter int             W    = 32,
   parameter logic [W-1:0]   IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("sticky_w1c_reg: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_impl
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (evt_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
         end
         assign q_o[i] = q;
      end else begin : g_tie
         assign q_o[i] = 1'b0;
      end
   end

   logic unused_bits;
   assign unused_bits = ^(evt_i & ~IMPL) ^ ^(clr_i & ~IMPL);

   // R2: an implemented pulse is visible after the edge
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));
   // R2: no bit rises without its pulse
   p_no_spont_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & ~$past(q_o) & ~$past(evt_i)) == '0));
   // R3: a write-one without a pulse clears
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(clr_i & ~evt_i)) == '0));
   // R4: a pulse beats a clear on the same bit
   p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      |(evt_i & clr_i & IMPL) |=> ((q_o & $past(evt_i & clr_i & IMPL)) != '0));
endmodule

// File: rtl/err_summary.sv
module err_summary
   import safety_agg_pkg::*;
(
   input  logic [DATA_W-1:0]  ctl_q_i,
   input  logic [QM_W-1:0]    qm_q_i,
   input  logic [DM_W-1:0]    dm_q_i,
   input  logic [QM_GROUPS-1:0] qm_en_i,
   input  logic               dm_en_i,
   output logic [2:0]         sum_q_o,
   output logic [2:0]         sum_d_o,
   output logic               irq_o
);
   logic [QM_GROUPS-1:0] corr_hit;
   logic [QM_GROUPS-1:0] unc_hit;
   logic [QM_GROUPS-1:0] unused_rsv;
   logic                 ctl_flag;

   for (genvar g = 0; g < QM_GROUPS; g++) begin : g_grp
      assign corr_hit[g]   = qm_q_i[g*GRP_W+POS_CORR] & qm_en_i[g];
      assign unc_hit[g]    = qm_q_i[g*GRP_W+POS_AMIS] | qm_q_i[g*GRP_W+POS_UNC];
      assign unused_rsv[g] = qm_q_i[g*GRP_W+3];
   end

   assign ctl_flag = |ctl_q_i;
   assign sum_q_o  = {|unc_hit, |corr_hit, ctl_flag};
   assign sum_d_o  = {dm_q_i[POS_AMIS] | dm_q_i[POS_UNC], dm_q_i[POS_CORR] & dm_en_i, ctl_flag};
   assign irq_o    = (|sum_q_o) | (|sum_d_o);
endmodule

// File: rtl/safety_err_agg.sv
module safety_err_agg
   import safety_agg_pkg::*;
#(
   parameter int SAFETY_LEVEL = 3,
   parameter int ADDR_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ctl_evt_i,
   input  logic [15:0]       qm_evt_i,
   input  logic [2:0]        dm_evt_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] CTL_MASK = ctl_impl(SAFETY_LEVEL);
   localparam logic [QM_W-1:0]   QM_MASK  = qm_impl(SAFETY_LEVEL);
   localparam logic [DM_W-1:0]   DM_MASK  = dm_impl(SAFETY_LEVEL);
   localparam logic [QM_W-1:0]   QM_UNC   = QM_MASK & 16'h6666;

   if (SAFETY_LEVEL < 0 || SAFETY_LEVEL > 3) begin : g_bad_lvl
      $error("safety_err_agg: SAFETY_LEVEL must be 0..3");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("safety_err_agg: ADDR_W must be at least 3");
   end

   logic wr_en;
   logic [DATA_W-1:0] ctl_q;
   logic [QM_W-1:0]   qm_q;
   logic [DM_W-1:0]   dm_q;
   logic [QM_GROUPS-1:0] qm_en;
   logic                 dm_en;
   logic [2:0] sum_q, sum_d;

   assign wr_en = bus_sel_i & bus_wr_i;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
      return a == ADDR_W'(r);
   endfunction

   sticky_w1c_reg #(.W(DATA_W), .IMPL(CTL_MASK)) u_ctl (
      .clk, .rst_n, .evt_i(ctl_evt_i),
      .clr_i((wr_en && hit(bus_addr_i, RA_CTL)) ? bus_wdata_i : '0),
      .q_o(ctl_q));

   sticky_w1c_reg #(.W(QM_W), .IMPL(QM_MASK)) u_qm (
      .clk, .rst_n, .evt_i(qm_evt_i),
      .clr_i((wr_en && hit(bus_addr_i, RA_QMEM)) ? bus_wdata_i[QM_W-1:0] : '0),
      .q_o(qm_q));

   sticky_w1c_reg #(.W(DM_W), .IMPL(DM_MASK)) u_dm (
      .clk, .rst_n, .evt_i(dm_evt_i),
      .clr_i((wr_en && hit(bus_addr_i, RA_DMEM)) ? bus_wdata_i[DM_W-1:0] : '0),
      .q_o(dm_q));

   if (SAFETY_LEVEL >= 1) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            qm_en <= '0;
            dm_en <= 1'b0;
         end else if (wr_en) begin
            if (hit(bus_addr_i, RA_QEN)) qm_en <= bus_wdata_i[QM_GROUPS-1:0];
            if (hit(bus_addr_i, RA_DEN)) dm_en <= bus_wdata_i[0];
         end
      end
   end else begin : g_no_en
      assign qm_en = '0;
      assign dm_en = 1'b0;
   end

   err_summary u_sum (
      .ctl_q_i(ctl_q), .qm_q_i(qm_q), .dm_q_i(dm_q),
      .qm_en_i(qm_en), .dm_en_i(dm_en),
      .sum_q_o(sum_q), .sum_d_o(sum_d), .irq_o(irq_o));

   always_comb begin
      bus_rdata_o = '0;
      if (hit(bus_addr_i, RA_CTL))  bus_rdata_o = ctl_q;
      if (hit(bus_addr_i, RA_QMEM)) bus_rdata_o[QM_W-1:0] = qm_q;
      if (hit(bus_addr_i, RA_DMEM)) bus_rdata_o[DM_W-1:0] = dm_q;
      if (hit(bus_addr_i, RA_QEN))  bus_rdata_o[QM_GROUPS-1:0] = qm_en;
      if (hit(bus_addr_i, RA_DEN))  bus_rdata_o[0] = dm_en;
      if (hit(bus_addr_i, RA_SUMQ)) bus_rdata_o[2:0] = sum_q;
      if (hit(bus_addr_i, RA_SUMD)) bus_rdata_o[2:0] = sum_d;
   end

   logic unused_wd;
   assign unused_wd = ^bus_wdata_i;

   // R10: any uncorrectable, mismatch or control status raises the interrupt
   p_unc_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(qm_q & QM_UNC)) || dm_q[POS_AMIS] || dm_q[POS_UNC] || (|ctl_q)) |-> irq_o);
   // R10: a masked correctable-only state leaves the interrupt low
   p_corr_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_q == '0) && ((qm_q & QM_UNC) == '0) && !dm_q[POS_AMIS] && !dm_q[POS_UNC]
       && (qm_en == '0) && !dm_en) |-> !irq_o);
endmodule

// File: tb/sim_safety_err_agg.sv
module sim_safety_err_agg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] ctl_evt = '0;
   logic [15:0] qm_evt = '0;
   logic [2:0]  dm_evt = '0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd [3];
   logic        irq [3];
   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int lv [3] = '{3, 1, 0};

   logic [31:0] m_ctl [3];
   logic [15:0] m_qm [3];
   logic [2:0]  m_dm [3];
   logic [3:0]  m_qen [3];
   logic        m_den [3];

   always #10 clk = ~clk;

   safety_err_agg #(.SAFETY_LEVEL(3), .ADDR_W(3)) u0 (.clk, .rst_n, .ctl_evt_i(ctl_evt),
      .qm_evt_i(qm_evt), .dm_evt_i(dm_evt), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd[0]), .irq_o(irq[0]));
   safety_err_agg #(.SAFETY_LEVEL(1), .ADDR_W(3)) u1 (.clk, .rst_n, .ctl_evt_i(ctl_evt),
      .qm_evt_i(qm_evt), .dm_evt_i(dm_evt), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd[1]), .irq_o(irq[1]));
   safety_err_agg #(.SAFETY_LEVEL(0), .ADDR_W(3)) u2 (.clk, .rst_n, .ctl_evt_i(ctl_evt),
      .qm_evt_i(qm_evt), .dm_evt_i(dm_evt), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd[2]), .irq_o(irq[2]));

   function automatic logic [31:0] ctl_mask(int l);
      return (l >= 3) ? 32'h010F_FFFF : (l == 2) ? 32'h010F_FFDE : 32'h0;
   endfunction
   function automatic logic [15:0] qm_mask(int l);
      return (l >= 1) ? 16'h7777 : 16'h0;
   endfunction

   function automatic logic [2:0] sum_q(int k);
      logic c = 1'b0, u = 1'b0;
      for (int g = 0; g < 4; g++) begin
         c = c | (m_qm[k][4*g] & m_qen[k][g]);
         u = u | m_qm[k][4*g+1] | m_qm[k][4*g+2];
      end
      return {u, c, |m_ctl[k]};
   endfunction
   function automatic logic [2:0] sum_d(int k);
      return {m_dm[k][1] | m_dm[k][2], m_dm[k][0] & m_den[k], |m_ctl[k]};
   endfunction
   function automatic logic [31:0] exp_rd(int k, logic [2:0] a);
      case (a)
         3'd0: return m_ctl[k];
         3'd1: return {16'h0, m_qm[k]};
         3'd2: return {29'h0, m_dm[k]};
         3'd3: return {28'h0, m_qen[k]};
         3'd4: return {31'h0, m_den[k]};
         3'd5: return {29'h0, sum_q(k)};
         3'd6: return {29'h0, sum_d(k)};
         default: return 32'h0;
      endcase
   endfunction
   function automatic string rd_req(int k, logic [2:0] a);
      if (lv[k] == 0) return "R7";
      case (a)
         3'd0: return "R5";
         3'd1, 3'd2: return "R6";
         3'd3, 3'd4: return "R8";
         3'd5, 3'd6: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < 3; k++) begin
         m_ctl[k] = '0; m_qm[k] = '0; m_dm[k] = '0; m_qen[k] = '0; m_den[k] = 1'b0;
      end
   endtask

   // one bus/event cycle: drive at falling edge, check pre-edge state, update model at rising edge
   task automatic step(logic s, logic w, logic [2:0] a, logic [31:0] d,
                       logic [31:0] ce, logic [15:0] qe, logic [2:0] de, string tag = "");
      @(negedge clk);
      sel = s; wr = w; addr = a; wdata = d; ctl_evt = ce; qm_evt = qe; dm_evt = de;
      #2;
      for (int k = 0; k < 3; k++) begin
         check((lv[k] == 0) ? "R7" : "R10", {31'h0, irq[k]}, {31'h0, |{sum_q(k), sum_d(k)}});
         if (s && !w) check((tag != "") ? tag : rd_req(k, a), rd[k], exp_rd(k, a));
      end
      @(posedge clk);
      for (int k = 0; k < 3; k++) begin
         logic [31:0] cl;
         cl = (s && w && a == 3'd0) ? d : 32'h0;
         m_ctl[k] = ((m_ctl[k] & ~cl) | ce) & ctl_mask(lv[k]);
         cl = (s && w && a == 3'd1) ? d : 32'h0;
         m_qm[k] = ((m_qm[k] & ~cl[15:0]) | qe) & qm_mask(lv[k]);
         cl = (s && w && a == 3'd2) ? d : 32'h0;
         m_dm[k] = ((m_dm[k] & ~cl[2:0]) | de) & ((lv[k] >= 1) ? 3'h7 : 3'h0);
         if (lv[k] >= 1 && s && w && a == 3'd3) m_qen[k] = d[3:0];
         if (lv[k] >= 1 && s && w && a == 3'd4) m_den[k] = d[0];
      end
   endtask

   task automatic rd_cycle(logic [2:0] a, string tag = "");
      step(1'b1, 1'b0, a, 32'h0, 32'h0, 16'h0, 3'h0, tag);
   endtask
   task automatic wr_cycle(logic [2:0] a, logic [31:0] d);
      step(1'b1, 1'b1, a, d, 32'h0, 16'h0, 3'h0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state of every offset
      for (int a = 0; a < 7; a++) rd_cycle(3'(a), "R1");
      for (int k = 0; k < 3; k++) check("R1", {31'h0, irq[k]}, 32'h0);

      // R2/R5: control bit 7 at level 3 and 2 only; bit 0 only at level 3
      step(1'b0, 1'b0, 3'd0, 32'h0, 32'h0000_0081, 16'h0, 3'h0);
      rd_cycle(3'd0, "R2");
      rd_cycle(3'd0, "R5");
      // R4: pulse and clear same cycle keep the bit
      step(1'b1, 1'b1, 3'd0, 32'h0000_0080, 32'h0000_0080, 16'h0, 3'h0);
      rd_cycle(3'd0, "R4");
      // R3: writing zero changes nothing, writing one clears
      wr_cycle(3'd0, 32'h0);
      rd_cycle(3'd0, "R3");
      wr_cycle(3'd0, 32'hFFFF_FFFF);
      rd_cycle(3'd0, "R3");
      // R6: all queue bits pulsed, reserved bits stay zero
      step(1'b0, 1'b0, 3'd0, 32'h0, 32'h0, 16'hFFFF, 3'h7);
      rd_cycle(3'd1, "R6");
      rd_cycle(3'd2, "R6");
      rd_cycle(3'd5, "R9");
      wr_cycle(3'd1, 32'hFFFF);
      wr_cycle(3'd2, 32'h7);
      // R10: TX correctable alone, enable off then on
      step(1'b0, 1'b0, 3'd0, 32'h0, 32'h0, 16'h0001, 3'h0);
      rd_cycle(3'd5, "R10");
      wr_cycle(3'd3, 32'hFFFF_FFF1);
      rd_cycle(3'd3, "R8");
      rd_cycle(3'd5, "R10");
      // R9: writes to summaries ignored; R11: unmapped reads zero
      wr_cycle(3'd5, 32'h0);
      wr_cycle(3'd6, 32'hFFFF_FFFF);
      rd_cycle(3'd5, "R9");
      rd_cycle(3'd7, "R11");
      wr_cycle(3'd1, 32'hFFFF);
      wr_cycle(3'd3, 32'h0);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] ce, d;
         logic [15:0] qe;
         logic [2:0]  de, a;
         logic s, w;
         ce = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
         qe = ($urandom % 6 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
         de = ($urandom % 8 == 0) ? (3'h1 << ($urandom % 3)) : 3'h0;
         s = ($urandom % 4 != 0);
         w = ($urandom % 3 == 0);
         a = 3'($urandom % 8);
         d = ($urandom % 2 == 0) ? $urandom : 32'h0 | (32'h1 << ($urandom % 32));
         step(s, w, a, d, ce, qe, de);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule